// File: doc/BRIEF.md
# Vector Integer Add/Subtract Unit with Per-Lane Carry Masks

This block performs unsigned integer addition and subtraction across a parameterised number of lanes (64 by default) in a single cycle, and registers the outcome. Each lane takes a 32-bit operand from each of two source vectors. Every lane applies the same operation, picked by a 4-bit operation code. The operations are plain add and subtract, reversed subtract, the three carry- or borrow-consuming forms, and three 16-bit forms. A clamp flag makes the result saturate instead of wrap.

Carries do not travel as a single scalar flag. They travel as a wave-wide mask in which lane i owns bit i. The incoming mask supplies carry-in or borrow-in to the consuming operations, and the outgoing mask collects each lane's carry-out or borrow-out. An execution mask selects the active lanes. Inactive lanes contribute zero to both the result vector and the carry mask, and a per-lane write enable tells a downstream register file which lanes to update. Forms that produce no carry leave the carry mask untouched and say so through a write strobe.

Top module: `lane_arith_unit`

## Requirements
- R1: While reset is high, and after it is released, the unit holds all of the following at zero until the first valid input: `out_valid`, `carry_wr`, `lane_we`, `carry_out` and `result_flat`.
- R2: The outputs of an operation appear one clock edge after the cycle in which `in_valid` is high, and `out_valid` is high for exactly that one cycle.
- R3: Code 0 (add) and code 3 (add with carry-in) produce the low 32 bits of A+B, or of A+B+cin[i] for code 3. The carry of lane i is set when that sum exceeds 0xFFFFFFFF.
- R4: The subtract codes differ in operands and borrow-in. Code 1 computes A−B, code 2 computes B−A, code 4 computes A−B−cin[i], and code 5 computes B−A−cin[i]. Each yields the low 32 bits, and the borrow of lane i is set when the true difference is negative.
- R5: With `clamp` high, a 32-bit add whose carry is set yields 0xFFFFFFFF, and a 32-bit subtract whose borrow is set yields 0. The carry or borrow bit is still reported.
- R6: Codes 6 (add), 7 (A−B) and 8 (B−A) use only bits [15:0] of each operand and return the low 16 bits zero-extended to 32 bits. With `clamp`, an add above 0xFFFF yields 0xFFFF and a negative difference yields 0.
- R7: A lane whose `exec_mask` bit is 0 gets a result of 0 and a carry-out bit of 0. After a valid input, `lane_we` equals the execution mask of that input; at all other times it is 0.
- R8: Codes 3, 4 and 5 always write the carry mask. Codes 0, 1 and 2 write it only when `carry_en` is high. A write raises `carry_wr` with the new mask. When no write happens, `carry_wr` is low and `carry_out` keeps its previous value.
- R9: Codes 0, 1, 2 and the 16-bit codes ignore `carry_in`.
- R10: Codes 9 to 15 produce a zero result in every lane and do not write the carry mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op | input | 4 | Operation code (see R3, R4, R6, R10) |
| carry_en | input | 1 | Request carry mask output for codes 0, 1, 2 |
| clamp | input | 1 | Saturate instead of wrap |
| exec_mask | input | LANES | Active lanes |
| src_a_flat | input | LANES*32 | Operand A, lane i in bits [32i+31:32i] |
| src_b_flat | input | LANES*32 | Operand B, same packing |
| carry_in | input | LANES | Carry/borrow-in, bit i for lane i |
| out_valid | output | 1 | Registered outputs are new |
| result_flat | output | LANES*32 | Results, same packing as sources |
| lane_we | output | LANES | Per-lane write enable |
| carry_out | output | LANES | Carry/borrow-out mask, bit i for lane i |
| carry_wr | output | 1 | `carry_out` was written this cycle |

## Verification
The assertions check several properties on every cycle. They confirm the one-cycle valid latency and that disabled lanes never show a nonzero result or carry bit. They also confirm that the carry mask stays unchanged whenever no write is flagged, and that 16-bit operations never set a high result bit or raise a carry write. The actual values of sums and differences, the saturation points, borrow detection with borrow-in, reversed operand order, and the indifference of the plain forms to the carry-in mask can only be shown by the bench. It compares every lane against its own 64-bit recomputation over operands chosen to sit at 0, 0xFFFF, 0x80000000 and 0xFFFFFFFF.

// File: rtl/lane_arith_pkg.sv
package lane_arith_pkg;

  typedef enum logic [3:0] {
    OP_ADD      = 4'd0,
    OP_SUB      = 4'd1,
    OP_SUBREV   = 4'd2,
    OP_ADDC     = 4'd3,
    OP_SUBB     = 4'd4,
    OP_SUBBREV  = 4'd5,
    OP_ADD16    = 4'd6,
    OP_SUB16    = 4'd7,
    OP_SUBREV16 = 4'd8
  } alu_op_e;

  // operation consumes the carry_in mask
  function automatic logic uses_carry_in(input logic [3:0] code);
    return (code == OP_ADDC) || (code == OP_SUBB) || (code == OP_SUBBREV);
  endfunction

  // operands swapped before the subtract
  function automatic logic swaps_operands(input logic [3:0] code);
    return (code == OP_SUBREV) || (code == OP_SUBBREV) || (code == OP_SUBREV16);
  endfunction

  function automatic logic is_half_op(input logic [3:0] code);
    return (code == OP_ADD16) || (code == OP_SUB16) || (code == OP_SUBREV16);
  endfunction

  // carry mask is written by this code under this enable
  function automatic logic writes_carry(input logic [3:0] code, input logic en);
    logic plain;
    plain = (code == OP_ADD) || (code == OP_SUB) || (code == OP_SUBREV);
    return uses_carry_in(code) || (plain && en);
  endfunction

endpackage

// File: rtl/lane_alu.sv
module lane_alu
  import lane_arith_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [3:0]    op,
  input  logic          clamp,
  input  logic          cin,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res,
  output logic          cout
);
  localparam int HW = DW / 2;

  // wide add: top bit is the carry
  function automatic logic [DW:0] add_wide(input logic [DW-1:0] x, input logic [DW-1:0] y,
                                           input logic c);
    return {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, c};
  endfunction

  // wide subtract: top bit set when the true difference is negative
  function automatic logic [DW:0] sub_wide(input logic [DW-1:0] x, input logic [DW-1:0] y,
                                           input logic c);
    return {1'b0, x} - {1'b0, y} - {{DW{1'b0}}, c};
  endfunction

  function automatic logic [HW:0] add_half(input logic [HW-1:0] x, input logic [HW-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  function automatic logic [HW:0] sub_half(input logic [HW-1:0] x, input logic [HW-1:0] y);
    return {1'b0, x} - {1'b0, y};
  endfunction

  function automatic logic [DW-1:0] sat_high(input logic [DW:0] w, input logic cl);
    return (cl && w[DW]) ? {DW{1'b1}} : w[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] sat_low(input logic [DW:0] w, input logic cl);
    return (cl && w[DW]) ? {DW{1'b0}} : w[DW-1:0];
  endfunction

  logic [DW-1:0] x_op, y_op;
  logic          c_eff;
  logic [DW:0]   sum_w, dif_w;
  logic [HW:0]   hsum_w, hdif_w;
  logic [HW-1:0] hres;

  assign x_op   = swaps_operands(op) ? b : a;
  assign y_op   = swaps_operands(op) ? a : b;
  assign c_eff  = uses_carry_in(op) & cin;
  assign sum_w  = add_wide(x_op, y_op, c_eff);
  assign dif_w  = sub_wide(x_op, y_op, c_eff);
  assign hsum_w = add_half(x_op[HW-1:0], y_op[HW-1:0]);
  assign hdif_w = sub_half(x_op[HW-1:0], y_op[HW-1:0]);

  always_comb begin
    res  = '0;
    cout = 1'b0;
    hres = '0;
    case (op)
      OP_ADD, OP_ADDC: begin
        cout = sum_w[DW];
        res  = sat_high(sum_w, clamp);
      end
      OP_SUB, OP_SUBREV, OP_SUBB, OP_SUBBREV: begin
        cout = dif_w[DW];
        res  = sat_low(dif_w, clamp);
      end
      OP_ADD16: begin
        hres = (clamp && hsum_w[HW]) ? {HW{1'b1}} : hsum_w[HW-1:0];
        res  = {{(DW-HW){1'b0}}, hres};
      end
      OP_SUB16, OP_SUBREV16: begin
        hres = (clamp && hdif_w[HW]) ? {HW{1'b0}} : hdif_w[HW-1:0];
        res  = {{(DW-HW){1'b0}}, hres};
      end
      default: begin
        res  = '0;
        cout = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/lane_alu_array.sv
module lane_alu_array #(
  parameter int LANES = 64,
  parameter int DW    = 32
) (
  input  logic [3:0]          op,
  input  logic                clamp,
  input  logic [LANES-1:0]    exec_mask,
  input  logic [LANES*DW-1:0] a_flat,
  input  logic [LANES*DW-1:0] b_flat,
  input  logic [LANES-1:0]    cin_mask,
  output logic [LANES*DW-1:0] res_flat,
  output logic [LANES-1:0]    cout_mask
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DW-1:0] r;
    logic          co;

    lane_alu #(.DW(DW)) u_alu (
      .op    (op),
      .clamp (clamp),
      .cin   (cin_mask[g]),
      .a     (a_flat[g*DW +: DW]),
      .b     (b_flat[g*DW +: DW]),
      .res   (r),
      .cout  (co)
    );

    assign res_flat[g*DW +: DW] = exec_mask[g] ? r : '0;
    assign cout_mask[g]         = exec_mask[g] & co;
  end

endmodule

// File: rtl/lane_out_reg.sv
module lane_out_reg #(
  parameter int LANES = 64,
  parameter int DW    = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                carry_wr_d,
  input  logic [LANES-1:0]    exec_mask,
  input  logic [LANES*DW-1:0] res_d,
  input  logic [LANES-1:0]    cout_d,
  output logic                out_valid,
  output logic [LANES*DW-1:0] result_q,
  output logic [LANES-1:0]    lane_we,
  output logic [LANES-1:0]    carry_q,
  output logic                carry_wr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      carry_wr  <= 1'b0;
      lane_we   <= '0;
      carry_q   <= '0;
      result_q  <= '0;
    end else begin
      out_valid <= in_valid;
      carry_wr  <= carry_wr_d;
      lane_we   <= in_valid ? exec_mask : '0;
      if (in_valid)   result_q <= res_d;
      if (carry_wr_d) carry_q  <= cout_d;
    end
  end

endmodule

// File: rtl/lane_arith_unit.sv
module lane_arith_unit
  import lane_arith_pkg::*;
#(
  parameter int LANES = 64,
  parameter int DW    = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [3:0]          op,
  input  logic                carry_en,
  input  logic                clamp,
  input  logic [LANES-1:0]    exec_mask,
  input  logic [LANES*DW-1:0] src_a_flat,
  input  logic [LANES*DW-1:0] src_b_flat,
  input  logic [LANES-1:0]    carry_in,
  output logic                out_valid,
  output logic [LANES*DW-1:0] result_flat,
  output logic [LANES-1:0]    lane_we,
  output logic [LANES-1:0]    carry_out,
  output logic                carry_wr
);
  localparam int VW = LANES * DW;

  // named internal events for the checker
  logic [VW-1:0]    lane_res;
  logic [LANES-1:0] lane_cout;
  logic             carry_wr_d;

  assign carry_wr_d = in_valid & writes_carry(op, carry_en);

  lane_alu_array #(.LANES(LANES), .DW(DW)) u_array (
    .op        (op),
    .clamp     (clamp),
    .exec_mask (exec_mask),
    .a_flat    (src_a_flat),
    .b_flat    (src_b_flat),
    .cin_mask  (carry_in),
    .res_flat  (lane_res),
    .cout_mask (lane_cout)
  );

  lane_out_reg #(.LANES(LANES), .DW(DW)) u_out (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .carry_wr_d (carry_wr_d),
    .exec_mask  (exec_mask),
    .res_d      (lane_res),
    .cout_d     (lane_cout),
    .out_valid  (out_valid),
    .result_q   (result_flat),
    .lane_we    (lane_we),
    .carry_q    (carry_out),
    .carry_wr   (carry_wr)
  );

endmodule

// File: rtl/lane_arith_checker.sv
module lane_arith_checker
  import lane_arith_pkg::*;
#(
  parameter int LANES = 64,
  parameter int DW    = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [3:0]          op,
  input logic                carry_wr_d,
  input logic                out_valid,
  input logic [LANES*DW-1:0] result_flat,
  input logic [LANES-1:0]    lane_we,
  input logic [LANES-1:0]    carry_out,
  input logic                carry_wr
);
  localparam int HW = DW / 2;

  logic hi_any, idle_any;
  always_comb begin
    hi_any   = 1'b0;
    idle_any = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      hi_any = hi_any | (|result_flat[i*DW+HW +: HW]);
      if (!lane_we[i]) idle_any = idle_any | (|result_flat[i*DW +: DW]);
    end
  end

  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_fall_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_idle_no_we_R7: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> lane_we == '0);
  assert_inactive_carry_R7: assert property (@(posedge clk) disable iff (rst)
    carry_wr |-> (carry_out & ~lane_we) == '0);
  assert_inactive_result_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !idle_any);
  assert_carry_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !carry_wr |-> $stable(carry_out));
  assert_carry_wr_valid_R8: assert property (@(posedge clk) disable iff (rst)
    carry_wr |-> out_valid);
  assert_carry_pipe_R8: assert property (@(posedge clk) disable iff (rst)
    carry_wr_d |=> carry_wr);
  assert_half_no_carry_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_half_op(op)) |=> !carry_wr);
  assert_half_high_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_half_op(op)) |=> !hi_any);

endmodule

bind lane_arith_unit lane_arith_checker #(.LANES(LANES), .DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .op          (op),
  .carry_wr_d  (carry_wr_d),
  .out_valid   (out_valid),
  .result_flat (result_flat),
  .lane_we     (lane_we),
  .carry_out   (carry_out),
  .carry_wr    (carry_wr)
);

// File: tb/test_lane_arith_unit.sv
`timescale 1ns/1ps
module test_lane_arith_unit;
  localparam int LANES = 64;
  localparam int VW    = LANES * 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [3:0]       op = '0;
  logic             carry_en = 1'b0;
  logic             clamp = 1'b0;
  logic [LANES-1:0] exec_mask = '0;
  logic [VW-1:0]    src_a_flat = '0;
  logic [VW-1:0]    src_b_flat = '0;
  logic [LANES-1:0] carry_in = '0;
  logic             out_valid;
  logic [VW-1:0]    result_flat;
  logic [LANES-1:0] lane_we;
  logic [LANES-1:0] carry_out;
  logic             carry_wr;

  int checks = 0;
  int errors = 0;
  logic [LANES-1:0] model_carry = '0;
  logic [LANES-1:0] all_on = '1;

  always #10 clk = ~clk;

  lane_arith_unit #(.LANES(LANES), .DW(32)) i_lane_arith_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .carry_en(carry_en),
    .clamp(clamp), .exec_mask(exec_mask), .src_a_flat(src_a_flat),
    .src_b_flat(src_b_flat), .carry_in(carry_in), .out_valid(out_valid),
    .result_flat(result_flat), .lane_we(lane_we), .carry_out(carry_out),
    .carry_wr(carry_wr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] gen(input int seed, input int lane, input int k);
    case ((lane + seed + k) % 6)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h0000_FFFF;
      3: return 32'h8000_0000;
      4: return 32'h0000_8001;
      default: return (lane * 32'h9E37_79B1) + (seed * 32'h7F4A_7C15) + k * 13;
    endcase
  endfunction

  // reference: recompute each operation at 64-bit width
  task automatic ref_lane(input int code, input bit ce, input bit cl,
                          input logic [31:0] a, input logic [31:0] b, input bit ci,
                          output logic [31:0] r, output bit co, output bit wr);
    longint unsigned t;
    int s;
    r = 0; co = 0; wr = 0;
    case (code)
      0, 3: begin
        t = 64'(a) + 64'(b) + ((code == 3) ? 64'(ci) : 64'd0);
        co = (t >> 32) != 0;
        r = (cl && co) ? 32'hFFFF_FFFF : t[31:0];
        wr = (code == 3) ? 1'b1 : ce;
      end
      1, 2, 4, 5: begin
        if (code == 1 || code == 4) t = 64'(a) - 64'(b);
        else                        t = 64'(b) - 64'(a);
        if (code >= 4) t = t - 64'(ci);
        co = (t >> 32) != 0;
        r = (cl && co) ? 32'd0 : t[31:0];
        wr = (code >= 4) ? 1'b1 : ce;
      end
      6: begin
        s = int'(a[15:0]) + int'(b[15:0]);
        r = (cl && s > 65535) ? 32'h0000_FFFF : {16'd0, s[15:0]};
      end
      7, 8: begin
        s = (code == 7) ? int'(a[15:0]) - int'(b[15:0]) : int'(b[15:0]) - int'(a[15:0]);
        r = (cl && s < 0) ? 32'd0 : {16'd0, s[15:0]};
      end
      default: r = 0;
    endcase
  endtask

  task automatic run_op(input string req, input int code, input bit ce, input bit cl,
                        input logic [LANES-1:0] ex, input logic [LANES-1:0] cin,
                        input int seed);
    logic [VW-1:0]    exp_res;
    logic [LANES-1:0] exp_co;
    bit               exp_wr;
    bit               res_ok;
    int               bad;
    @(negedge clk);
    op = code[3:0]; carry_en = ce; clamp = cl; exec_mask = ex; carry_in = cin;
    exp_wr = 0; exp_co = '0; exp_res = '0;
    for (int i = 0; i < LANES; i++) begin
      logic [31:0] r;
      bit co, wr;
      src_a_flat[i*32 +: 32] = gen(seed, i, 0);
      src_b_flat[i*32 +: 32] = gen(seed, i, 3);
      ref_lane(code, ce, cl, gen(seed, i, 0), gen(seed, i, 3), cin[i], r, co, wr);
      exp_wr = wr;
      if (ex[i]) begin
        exp_res[i*32 +: 32] = r;
        exp_co[i] = co;
      end
    end
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, "R2", "out_valid after input", 64'(out_valid), 64'd1);
    res_ok = 1; bad = 0;
    for (int i = LANES - 1; i >= 0; i--)
      if (result_flat[i*32 +: 32] !== exp_res[i*32 +: 32]) begin res_ok = 0; bad = i; end
    check(res_ok, req, $sformatf("result lane %0d op %0d", bad, code),
          64'(result_flat[bad*32 +: 32]), 64'(exp_res[bad*32 +: 32]));
    check(lane_we === ex, "R7", "lane_we", 64'(lane_we), 64'(ex));
    check(carry_wr === exp_wr, "R8", $sformatf("carry_wr op %0d", code),
          64'(carry_wr), 64'(exp_wr));
    if (exp_wr) model_carry = exp_co;
    check(carry_out === model_carry, exp_wr ? req : "R8",
          $sformatf("carry_out op %0d", code), 64'(carry_out), 64'(model_carry));
  endtask

  task automatic t_reset;
    check(out_valid === 1'b0 && carry_wr === 1'b0, "R1", "valid/strobe in reset",
          64'({out_valid, carry_wr}), 64'd0);
    check(lane_we === '0 && carry_out === '0, "R1", "masks in reset",
          64'(lane_we | carry_out), 64'd0);
    check(result_flat === '0, "R1", "result in reset", 64'(result_flat[63:0]), 64'd0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0 && lane_we === '0, "R1", "idle after reset",
          64'(out_valid), 64'd0);
  endtask

  task automatic t_plain32;
    run_op("R3", 0, 1, 0, all_on, 64'h5555_AAAA_0F0F_3C3C, 1);
    run_op("R4", 1, 1, 0, all_on, 64'h0, 2);
    run_op("R4", 2, 1, 0, all_on, 64'hFFFF_FFFF_FFFF_FFFF, 3);
  endtask

  task automatic t_carry_ops;
    run_op("R3", 3, 0, 0, all_on, 64'hFFFF_0000_FFFF_0000, 4);
    run_op("R4", 4, 0, 0, all_on, 64'hA5A5_5A5A_1234_8765, 5);
    run_op("R4", 5, 0, 0, all_on, 64'hFFFF_FFFF_FFFF_FFFF, 6);
  endtask

  task automatic t_clamp32;
    run_op("R5", 0, 1, 1, all_on, 64'h0, 7);
    run_op("R5", 3, 0, 1, all_on, 64'hFFFF_FFFF_FFFF_FFFF, 8);
    run_op("R5", 1, 1, 1, all_on, 64'h0, 9);
    run_op("R5", 5, 0, 1, all_on, 64'h3333_CCCC_3333_CCCC, 10);
  endtask

  task automatic t_half;
    run_op("R6", 6, 1, 0, all_on, 64'h0, 11);
    run_op("R6", 6, 1, 1, all_on, 64'h0, 12);
    run_op("R6", 7, 0, 0, all_on, 64'h0, 13);
    run_op("R6", 7, 0, 1, all_on, 64'h0, 14);
    run_op("R6", 8, 1, 1, all_on, 64'h0, 15);
  endtask

  task automatic t_exec;
    run_op("R7", 3, 0, 0, 64'hAAAA_AAAA_0000_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 16);
    run_op("R7", 1, 1, 0, 64'h0, 64'h0, 17);
    run_op("R7", 0, 1, 0, 64'h8000_0000_0000_0001, 64'h0, 18);
  endtask

  task automatic t_hold;
    run_op("R4", 4, 0, 0, all_on, 64'hFFFF_FFFF_0000_0000, 19);
    run_op("R8", 0, 0, 0, all_on, 64'h0, 20);
    run_op("R8", 6, 1, 1, all_on, 64'h0, 21);
    run_op("R8", 2, 0, 1, all_on, 64'h0, 22);
  endtask

  task automatic t_cin_ignored;
    run_op("R9", 0, 1, 0, all_on, 64'hFFFF_FFFF_FFFF_FFFF, 23);
    run_op("R9", 2, 1, 0, all_on, 64'hFFFF_FFFF_FFFF_FFFF, 24);
    run_op("R9", 7, 0, 0, all_on, 64'hFFFF_FFFF_FFFF_FFFF, 25);
  endtask

  task automatic t_bad_codes;
    run_op("R3", 3, 0, 0, all_on, 64'h0F0F_F0F0_0F0F_F0F0, 26);
    run_op("R10", 9, 1, 0, all_on, 64'hFFFF_FFFF_FFFF_FFFF, 27);
    run_op("R10", 15, 1, 1, all_on, 64'h0, 28);
  endtask

  task automatic t_latency;
    run_op("R2", 0, 0, 0, all_on, 64'h0, 29);
    @(negedge clk);
    check(out_valid === 1'b0, "R2", "out_valid single cycle", 64'(out_valid), 64'd0);
    check(lane_we === '0, "R7", "lane_we idle", 64'(lane_we), 64'd0);
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_plain32();
    t_carry_ops();
    t_clamp32();
    t_half();
    t_exec();
    t_hold();
    t_cin_ignored();
    t_bad_codes();
    t_latency();
    finish_run();
  end

endmodule